// File: doc/BRIEF.md
# Banked Wide Operand and Modulus Store

This block is the storage that sits beside a wide modular multiplier. It keeps several full-width operands and several moduli in registers. A 32-bit bus side loads them one word at a time and reads results back one word at a time. The multiplier side sees one chosen operand and one chosen modulus as full-width parallel vectors. It can also put a full-width result into an operand slot in a single cycle.

The bus side uses one flat address. The top bit picks the region: 0 for operands, 1 for moduli. The bits below it pick the slot, and the lowest bits pick the 32-bit word. Bus reads always come from the slot that currently receives results. In exponentiation mode that slot is the last operand slot. Otherwise an external destination select names it. When a bus write and a result load arrive in the same cycle, the result load is kept, the bus write is dropped, and a collision flag rises for one cycle.

Top module: `wide_operand_store`

## Requirements
- R1: The bus address is `{region, slot, word}`. The MSB is the region (0 = operand). The next `OSB = clog2(NUM_OPS)` bits are the slot. The low `WB = clog2(WIDTH/32)` bits are the word index. A bus write to operand slot s, word w, replaces bits [32w+31:32w] of slot s only.
- R2: A bus write with region bit 1 replaces only the addressed 32-bit word of modulus slot (slot field) and leaves every other word and slot unchanged.
- R3: `op_out` and `mod_out` are registered. They show the slot chosen by `op_sel` / `mod_sel` at the previous rising edge, so a change of select shows up one cycle later.
- R4: With `res_load` high, all WIDTH bits of `res_data` are written in that cycle into the destination operand slot.
- R5: With `exp_mode` high, the result destination is operand slot NUM_OPS-1 whatever `dest_sel` holds. With `exp_mode` low, it is `dest_sel`.
- R6: `bus_rdata` shows, one cycle after the address is presented, word `word` of the current result-destination slot (per R5). The region and slot address bits have no effect on a read. A word index of WIDTH/32 or more reads as 0.
- R7: When `bus_we` and `res_load` are high in the same cycle, the result write is performed, the bus write is discarded, and `collision` is high during the next cycle only. Otherwise `collision` is low.
- R8: A modulus write whose slot field is NUM_MODS or more changes no modulus slot.
- R9: During and right after synchronous reset (`rst` high), `collision`, `bus_rdata`, `op_out` and `mod_out` are 0.
- R10: A bus write whose word index is WIDTH/32 or more changes no stored value, in either region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus word write strobe |
| bus_addr | input | 1+OSB+WB | Flat address {region, slot, word} |
| bus_wdata | input | 32 | Bus write word |
| bus_rdata | output | 32 | Registered read word from the result slot |
| collision | output | 1 | Bus write and result load met in the previous cycle |
| op_sel | input | OSB | Operand slot shown on op_out |
| op_out | output | WIDTH | Selected operand, full width |
| mod_sel | input | MSB | Modulus slot shown on mod_out |
| mod_out | output | WIDTH | Selected modulus, full width |
| res_load | input | 1 | Full-width result write strobe |
| res_data | input | WIDTH | Result value |
| exp_mode | input | 1 | 1: result goes to last operand slot |
| dest_sel | input | OSB | Result slot when exp_mode is 0 |

## Verification
The bus-side word write and the multiplier-side result load can arrive in the same cycle. The bench provokes this by raising `bus_we` and `res_load` on the same edge. In one case the bus targets an operand slot other than the result destination. In the other it targets a modulus word. The outcome is judged at the ports: `collision` must be high for exactly the following cycle, the destination slot must hold the full result, and the slot or modulus word the bus aimed at must keep its old contents.

// File: rtl/wos_pkg.sv
package wos_pkg;
  typedef enum logic {
    REGION_OPERAND = 1'b0,
    REGION_MODULUS = 1'b1
  } region_e;

  function automatic int field_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wos_addr_decode.sv
module wos_addr_decode
  import wos_pkg::*;
#(
  parameter int WIDTH    = 1536,
  parameter int NUM_OPS  = 4,
  parameter int NUM_MODS = 2,
  localparam int WORDS   = WIDTH / 32,
  localparam int WB      = field_bits(WORDS),
  localparam int OSB     = field_bits(NUM_OPS),
  localparam int MSB     = field_bits(NUM_MODS),
  localparam int AW      = 1 + OSB + WB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic           res_load,
  output logic [WB-1:0]  word_idx,
  output logic [OSB-1:0] op_slot,
  output logic [MSB-1:0] mod_slot,
  output logic           op_we,
  output logic           mod_we,
  output logic           collision
);
  region_e        region;
  logic [OSB-1:0] slot_field;
  logic           word_ok;
  logic           mod_ok;
  logic           bus_pass;

  always_comb begin
    region     = region_e'(bus_addr[AW-1]);
    slot_field = bus_addr[AW-2 -: OSB];
    word_idx   = bus_addr[WB-1:0];
    op_slot    = slot_field;
    mod_slot   = slot_field[MSB-1:0];
    word_ok    = int'(word_idx) < WORDS;
    mod_ok     = int'(slot_field) < NUM_MODS;
    // the result write wins: a bus write in the same cycle is dropped
    bus_pass   = bus_we && !res_load && word_ok;
    op_we      = bus_pass && (region == REGION_OPERAND);
    mod_we     = bus_pass && (region == REGION_MODULUS) && mod_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) collision <= 1'b0;
    else     collision <= bus_we && res_load;
  end

  a_r7_collision_raised : assert property (@(posedge clk) disable iff (rst)
    (bus_we && res_load) |=> collision);
  a_r7_collision_single : assert property (@(posedge clk) disable iff (rst)
    !(bus_we && res_load) |=> !collision);
endmodule

// File: rtl/wos_operand_bank.sv
module wos_operand_bank #(
  parameter int WIDTH   = 1536,
  parameter int NUM_OPS = 4,
  parameter int WB      = 6,
  parameter int OSB     = 2,
  localparam int WORDS  = WIDTH / 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [OSB-1:0]   bus_slot,
  input  logic [WB-1:0]    bus_word,
  input  logic [31:0]      bus_wdata,
  input  logic             res_we,
  input  logic [OSB-1:0]   res_dest,
  input  logic [WIDTH-1:0] res_data,
  input  logic [OSB-1:0]   out_sel,
  output logic [WIDTH-1:0] out_vec,
  input  logic [OSB-1:0]   rd_slot,
  input  logic [WB-1:0]    rd_word,
  output logic [31:0]      rd_data
);
  logic [WIDTH-1:0] slot_q [NUM_OPS];

  function automatic logic [31:0] word_of(input logic [WIDTH-1:0] v, input int idx);
    return v[32*idx +: 32];
  endfunction

  for (genvar s = 0; s < NUM_OPS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (res_we && res_dest == OSB'(s))
        slot_q[s] <= res_data;
      else if (bus_we && bus_slot == OSB'(s))
        slot_q[s][32*int'(bus_word) +: 32] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vec <= '0;
      rd_data <= '0;
    end else begin
      out_vec <= slot_q[out_sel];
      rd_data <= (int'(rd_word) < WORDS) ? word_of(slot_q[rd_slot], int'(rd_word)) : 32'h0;
    end
  end

  a_r4_result_lands : assert property (@(posedge clk) disable iff (rst)
    res_we |=> slot_q[$past(res_dest)] == $past(res_data));
endmodule

// File: rtl/wos_modulus_bank.sv
module wos_modulus_bank #(
  parameter int WIDTH    = 1536,
  parameter int NUM_MODS = 2,
  parameter int WB       = 6,
  parameter int MSB      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [MSB-1:0]   bus_slot,
  input  logic [WB-1:0]    bus_word,
  input  logic [31:0]      bus_wdata,
  input  logic [MSB-1:0]   out_sel,
  output logic [WIDTH-1:0] out_vec
);
  logic [WIDTH-1:0] mod_q [NUM_MODS];

  function automatic logic [31:0] word_of(input logic [WIDTH-1:0] v, input int idx);
    return v[32*idx +: 32];
  endfunction

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    always_ff @(posedge clk) begin
      if (bus_we && bus_slot == MSB'(m))
        mod_q[m][32*int'(bus_word) +: 32] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_vec <= '0;
    else     out_vec <= mod_q[out_sel];
  end

  a_r2_word_written : assert property (@(posedge clk) disable iff (rst)
    bus_we |=> word_of(mod_q[$past(bus_slot)], int'($past(bus_word))) == $past(bus_wdata));
endmodule

// File: rtl/wide_operand_store.sv
module wide_operand_store
  import wos_pkg::*;
#(
  parameter int WIDTH    = 1536,
  parameter int NUM_OPS  = 4,
  parameter int NUM_MODS = 2,
  localparam int WORDS   = WIDTH / 32,
  localparam int WB      = field_bits(WORDS),
  localparam int OSB     = field_bits(NUM_OPS),
  localparam int MSB     = field_bits(NUM_MODS),
  localparam int AW      = 1 + OSB + WB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             collision,
  input  logic [OSB-1:0]   op_sel,
  output logic [WIDTH-1:0] op_out,
  input  logic [MSB-1:0]   mod_sel,
  output logic [WIDTH-1:0] mod_out,
  input  logic             res_load,
  input  logic [WIDTH-1:0] res_data,
  input  logic             exp_mode,
  input  logic [OSB-1:0]   dest_sel
);
  logic [WB-1:0]  word_idx;
  logic [OSB-1:0] op_slot;
  logic [MSB-1:0] mod_slot;
  logic           op_we;
  logic           mod_we;
  logic [OSB-1:0] eff_dest;

  assign eff_dest = exp_mode ? OSB'(NUM_OPS - 1) : dest_sel;

  wos_addr_decode #(.WIDTH(WIDTH), .NUM_OPS(NUM_OPS), .NUM_MODS(NUM_MODS)) i_decode (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .res_load(res_load),
    .word_idx(word_idx), .op_slot(op_slot), .mod_slot(mod_slot),
    .op_we(op_we), .mod_we(mod_we), .collision(collision)
  );

  wos_operand_bank #(.WIDTH(WIDTH), .NUM_OPS(NUM_OPS), .WB(WB), .OSB(OSB)) i_ops (
    .clk(clk), .rst(rst),
    .bus_we(op_we), .bus_slot(op_slot), .bus_word(word_idx), .bus_wdata(bus_wdata),
    .res_we(res_load), .res_dest(eff_dest), .res_data(res_data),
    .out_sel(op_sel), .out_vec(op_out),
    .rd_slot(eff_dest), .rd_word(word_idx), .rd_data(bus_rdata)
  );

  wos_modulus_bank #(.WIDTH(WIDTH), .NUM_MODS(NUM_MODS), .WB(WB), .MSB(MSB)) i_mods (
    .clk(clk), .rst(rst),
    .bus_we(mod_we), .bus_slot(mod_slot), .bus_word(word_idx), .bus_wdata(bus_wdata),
    .out_sel(mod_sel), .out_vec(mod_out)
  );

  initial begin
    if (WIDTH % 32 != 0 || NUM_OPS <= NUM_MODS)
      $error("wide_operand_store: bad parameters");
  end
endmodule

// File: tb/test_wide_operand_store.sv
`timescale 1ns/1ps
module test_wide_operand_store;
  localparam int W = 96, NO = 4, NM = 2, AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          collision;
  logic [1:0]    op_sel = '0;
  logic [W-1:0]  op_out;
  logic          mod_sel = 1'b0;
  logic [W-1:0]  mod_out;
  logic          res_load = 1'b0;
  logic [W-1:0]  res_data = '0;
  logic          exp_mode = 1'b0;
  logic [1:0]    dest_sel = '0;

  logic [W-1:0] e_op [NO];
  logic [W-1:0] e_mod [NM];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wide_operand_store #(.WIDTH(W), .NUM_OPS(NO), .NUM_MODS(NM)) i_wide_operand_store (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .collision(collision), .op_sel(op_sel), .op_out(op_out),
    .mod_sel(mod_sel), .mod_out(mod_out), .res_load(res_load), .res_data(res_data),
    .exp_mode(exp_mode), .dest_sel(dest_sel)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit region, input int slot, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {region, 2'(slot), 2'(word)}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (word < 3) begin
      if (!region) e_op[slot][32*word +: 32] = d;
      else if (slot < NM) e_mod[slot][32*word +: 32] = d;
    end
  endtask

  task automatic res_wr(input int dest, input bit expm, input logic [W-1:0] d);
    @(negedge clk);
    res_load = 1'b1; dest_sel = 2'(dest); exp_mode = expm; res_data = d;
    @(negedge clk);
    res_load = 1'b0;
    e_op[expm ? NO-1 : dest] = d;
  endtask

  task automatic peek_op(input int s, input string req);
    op_sel = 2'(s);
    @(negedge clk);
    chk(req, op_out, e_op[s]);
  endtask

  task automatic peek_mod(input int s, input string req);
    mod_sel = 1'(s);
    @(negedge clk);
    chk(req, mod_out, e_mod[s]);
  endtask

  task automatic bus_rd(input int word, input bit expm, input int dest, input string req);
    int eff;
    eff = expm ? NO-1 : dest;
    exp_mode = expm; dest_sel = 2'(dest);
    bus_addr = {3'b101, 2'(word)};
    @(negedge clk);
    chk(req, W'(bus_rdata), (word < 3) ? W'(e_op[eff][32*word +: 32]) : '0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R9 collision", W'(collision), '0);
    chk("R9 rdata", W'(bus_rdata), '0);
    chk("R9 op_out", op_out, '0);
    chk("R9 mod_out", mod_out, '0);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int s = 0; s < NO; s++)
      res_wr(s, 1'b0, {32'(32'h300 + s), 32'(32'h200 + s), 32'(32'h100 + s)});
    for (int s = 0; s < NO; s++) peek_op(s, "R4 full-width result load");
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 3; w++) bus_wr(1'b1, m, w, 32'hA000_0000 + 32'(m*16 + w));
    for (int m = 0; m < NM; m++) peek_mod(m, "R2 modulus fill");
  endtask

  task automatic t_op_write();
    bus_wr(1'b0, 2, 1, 32'hDEAD_BEEF);
    peek_op(2, "R1 word written");
    peek_op(1, "R1 other slot untouched");
  endtask

  task automatic t_mod_word();
    bus_wr(1'b1, 1, 2, 32'h5555_AAAA);
    peek_mod(1, "R2 single word, rest kept");
    peek_mod(0, "R2 other modulus kept");
  endtask

  task automatic t_latency();
    op_sel = 2'd3; mod_sel = 1'b1;
    @(negedge clk);
    op_sel = 2'd0; mod_sel = 1'b0;
    #1;
    chk("R3 op_out holds before edge", op_out, e_op[3]);
    chk("R3 mod_out holds before edge", mod_out, e_mod[1]);
    @(negedge clk);
    chk("R3 op_out after edge", op_out, e_op[0]);
    chk("R3 mod_out after edge", mod_out, e_mod[0]);
  endtask

  task automatic t_exp_dest();
    res_wr(1, 1'b1, 96'hE0E0_0001_E0E0_0002_E0E0_0003);
    peek_op(3, "R5 exp mode goes to last slot");
    peek_op(1, "R5 dest_sel ignored in exp mode");
    res_wr(1, 1'b0, 96'h1234_5678_9ABC_DEF0_0F0F_0F0F);
    peek_op(1, "R5 single mode follows dest_sel");
  endtask

  task automatic t_read();
    for (int w = 0; w < 3; w++) bus_rd(w, 1'b0, 2, "R6 read from dest slot");
    bus_rd(3, 1'b0, 2, "R6 out-of-range word reads 0");
    bus_rd(1, 1'b1, 0, "R6 read from last slot in exp mode");
    bus_rd(0, 1'b0, 1, "R6 read follows dest_sel");
  endtask

  task automatic t_collide();
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {1'b0, 2'd0, 2'd0}; bus_wdata = 32'hBAD0_0000;
    res_load = 1'b1; exp_mode = 1'b0; dest_sel = 2'd2; res_data = 96'hC011_0001_C011_0002_C011_0003;
    @(negedge clk);
    bus_we = 1'b0; res_load = 1'b0;
    e_op[2] = 96'hC011_0001_C011_0002_C011_0003;
    chk("R7 collision raised", W'(collision), W'(1));
    @(negedge clk);
    chk("R7 collision one cycle", W'(collision), '0);
    peek_op(2, "R7 result write kept");
    peek_op(0, "R7 bus operand write dropped");
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {1'b1, 2'd0, 2'd1}; bus_wdata = 32'hBAD0_0001;
    res_load = 1'b1; dest_sel = 2'd0; res_data = 96'h7;
    @(negedge clk);
    bus_we = 1'b0; res_load = 1'b0;
    e_op[0] = 96'h7;
    chk("R7 collision on modulus write", W'(collision), W'(1));
    peek_mod(0, "R7 bus modulus write dropped");
    peek_op(0, "R7 result write kept");
    bus_wr(1'b0, 3, 0, 32'h0000_3333);
    chk("R7 no collision for lone write", W'(collision), '0);
  endtask

  task automatic t_mod_slot_range();
    bus_wr(1'b1, 2, 0, 32'hFFFF_0000);
    bus_wr(1'b1, 3, 1, 32'hFFFF_0001);
    peek_mod(0, "R8 slot 2 not aliased");
    peek_mod(1, "R8 slot 3 not aliased");
  endtask

  task automatic t_word_range();
    bus_wr(1'b0, 1, 3, 32'h0BAD_0BAD);
    bus_wr(1'b1, 0, 3, 32'h0BAD_0BAD);
    peek_op(1, "R10 operand word 3 ignored");
    peek_mod(0, "R10 modulus word 3 ignored");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_op_write();
    t_mod_word();
    t_latency();
    t_exp_dest();
    t_read();
    t_collide();
    t_mod_slot_range();
    t_word_range();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule